// File: doc/BRIEF.md
# Virtual Link Transmit Regulator

This block paces and multiplexes outgoing frames of an avionics end system. Each virtual link (VL) owns several sub-queues of frame descriptors, where each descriptor is reduced to a frame length. The block also keeps a per-link gap timer, a maximum frame length and a two-bit network-enable mask. A link may send once its gap timer has run down and at least one of its sub-queues holds a descriptor. Within a link, the sub-queues take turns in round-robin order. Across links, the lowest-numbered eligible link wins.

The block selects one frame, stamps it with the link's next sequence number and presents it, with its network mask, to the replication stage downstream. It then waits for that stage to acknowledge before it selects again. The gap timer counts millisecond ticks supplied from outside and reloads to a power of two on every sent frame. A frame longer than its link's maximum is thrown away at selection time and counted. A discarded frame costs no gap time and no sequence number.

Top module: `vl_tx_regulator`

## Requirements
- R1: After reset no frame is presented, `drop_count` is 0, every link may send at once, and the first frame presented on each link carries sequence number 0.
- R2: `enq_accept` is high exactly when the sub-queue addressed by `enq_vl`/`enq_sub` holds fewer than QDEPTH descriptors. An accepted descriptor is stored only when `enq_valid` is also high. Each sub-queue releases its descriptors in arrival order, with their lengths unchanged.
- R3: Once a frame from link v has been presented, no further frame from v is selected until 2^e pulses of `ms_tick` have been seen. Here e is the 3-bit field `cfg_bag_exp[3v+2:3v]`, so the gap ranges from 1 to 128 ticks.
- R4: The block serves a link when no frame is outstanding, the link's gap has elapsed and one of its sub-queues is non-empty. Each discard takes one cycle, and a selected frame appears on the output the cycle after it is chosen.
- R5: When several links are eligible in the same cycle, the one with the lowest index is served first.
- R6: Within a link, service starts at the sub-queue after the one served last. A served sub-queue includes one whose frame was discarded. Service then proceeds cyclically and skips empty sub-queues.
- R7: A frame whose length exceeds `cfg_lmax[LEN_W*v +: LEN_W]` of its link is removed and not presented. Such a removal raises `drop_count` by one, leaves the gap timer and the sequence number untouched, and lets the block pick again. A frame whose length equals the limit is presented.
- R8: Each presented frame takes its link's current sequence number. The number then advances by one, and 255 is followed by 1, never by 0.
- R9: While `out_valid` is high, `out_vl`, `out_sub`, `out_len`, `out_seq` and `out_net_mask` hold still until a clock edge with `out_done` high. `out_valid` is low in the cycle after that edge. At most one frame is outstanding at any time.
- R10: `out_net_mask` equals `cfg_net_en[2v+1:2v]` of the selected link at the moment of selection, with bit 0 enabling network A and bit 1 enabling network B.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ms_tick | input | 1 | One-cycle pulse every millisecond |
| enq_valid | input | 1 | Descriptor write strobe |
| enq_vl | input | VL_W | Target link of the descriptor |
| enq_sub | input | SUB_W | Target sub-queue within the link |
| enq_len | input | LEN_W | Frame length in bytes |
| enq_accept | output | 1 | Addressed sub-queue has room |
| cfg_bag_exp | input | 3*NUM_VL | Per-link gap exponent, gap = 2^e ticks |
| cfg_lmax | input | LEN_W*NUM_VL | Per-link largest permitted frame length |
| cfg_net_en | input | 2*NUM_VL | Per-link network enable mask (bit0 A, bit1 B) |
| out_valid | output | 1 | A selected frame is presented |
| out_vl | output | VL_W | Link of the presented frame |
| out_sub | output | SUB_W | Sub-queue of the presented frame |
| out_len | output | LEN_W | Length of the presented frame |
| out_seq | output | 8 | Sequence number stamped on the frame |
| out_net_mask | output | 2 | Networks that shall carry the frame |
| out_done | input | 1 | Replication stage has taken the frame |
| drop_count | output | DROP_W | Number of frames discarded for length |

## Verification
A wrong gap timer shows at the ports within one tick. A frame then appears while the reference still holds the link back, or it fails to appear within the short settling window after the tick that should release it. A corrupted round-robin pointer or sequence register shows on the very next frame of that link, as a wrong `out_sub` or `out_seq`. Queue corruption shows as a wrong `out_len` or a wrong `enq_accept` at the next access to that sub-queue. A missed or doubled discard shifts `drop_count`, which is compared after every stimulus step.

// File: rtl/vlr_pkg.sv
// Shared constants, the scheduler state type and the sequence-number
// successor rule for the virtual link regulator.
package vlr_pkg;
    localparam int BAGX_W    = 3;              // gap exponent field width
    localparam int BAG_CNT_W = 1 << BAGX_W;    // holds 2^(2^BAGX_W - 1)
    localparam int SEQ_W     = 8;
    localparam int NET_W     = 2;

    typedef enum logic {
        SCH_IDLE = 1'b0,
        SCH_BUSY = 1'b1
    } sch_state_e;

    // Successor of a sequence number: all-ones wraps to 1, never to 0.
    function automatic logic [SEQ_W-1:0] seq_advance(input logic [SEQ_W-1:0] cur);
        if (cur == {SEQ_W{1'b1}}) begin
            return SEQ_W'(1);
        end
        return cur + SEQ_W'(1);
    endfunction
endpackage

// File: rtl/vlr_desc_fifo.sv
// Descriptor FIFO for one sub-queue. Holds frame lengths only.
// Assumes the owner never pops an empty FIFO; a push when full is ignored.
module vlr_desc_fifo #(
    parameter int DEPTH = 4,
    parameter int W     = 11
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic         pop,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = PTR_W + 1;

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_q, rd_q;
    logic [CNT_W-1:0] cnt_q;
    logic             do_push, do_pop;

    assign empty   = (cnt_q == '0);
    assign full    = (cnt_q == CNT_W'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rd_q];

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    // Storage write; contents need no reset.
    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wr_q] <= din;
        end
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (do_push) wr_q <= bump(wr_q);
            if (do_pop)  rd_q <= bump(rd_q);
            case ({do_push, do_pop})
                2'b10:   cnt_q <= cnt_q + CNT_W'(1);
                2'b01:   cnt_q <= cnt_q - CNT_W'(1);
                default: cnt_q <= cnt_q;
            endcase
        end
    end
endmodule

// File: rtl/vlr_bag_timer.sv
// Per-link gap timer. Reloads to 2^exp on a send and counts down one per
// millisecond tick. The link is ready at zero. A reload wins over a tick.
module vlr_bag_timer
    import vlr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ms_tick,
    input  logic              load,
    input  logic [BAGX_W-1:0] bag_exp,
    output logic              ready
);
    logic [BAG_CNT_W-1:0] cnt_q;

    assign ready = (cnt_q == '0);

    // Countdown with reload on transmission.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= BAG_CNT_W'(1) << bag_exp;
        end else if (ms_tick && !ready) begin
            cnt_q <= cnt_q - BAG_CNT_W'(1);
        end
    end
endmodule

// File: rtl/vlr_pick.sv
// Combinational selector. Takes the lowest-index link that is ready and has
// a non-empty sub-queue. Within that link it takes the first non-empty
// sub-queue at or after the link's round-robin pointer.
module vlr_pick #(
    parameter int NUM_VL  = 4,
    parameter int NUM_SUB = 2,
    parameter int VL_W    = 2,
    parameter int SUB_W   = 1
) (
    input  logic [NUM_VL-1:0]         vl_ready,
    input  logic [NUM_VL*NUM_SUB-1:0] q_nonempty,
    input  logic [NUM_VL*SUB_W-1:0]   rr_flat,
    output logic                      found,
    output logic [VL_W-1:0]           sel_vl,
    output logic [SUB_W-1:0]          sel_sub
);
    logic [NUM_SUB-1:0] cand;
    logic [SUB_W-1:0]   start;

    // Fixed priority across links; the descending scan leaves the lowest index.
    always_comb begin
        found  = 1'b0;
        sel_vl = '0;
        for (int v = NUM_VL - 1; v >= 0; v--) begin
            if (vl_ready[v] && (|q_nonempty[v*NUM_SUB +: NUM_SUB])) begin
                found  = 1'b1;
                sel_vl = VL_W'(v);
            end
        end
    end

    // Round-robin among the chosen link's sub-queues.
    always_comb begin
        cand    = q_nonempty[int'(sel_vl)*NUM_SUB +: NUM_SUB];
        start   = rr_flat[int'(sel_vl)*SUB_W +: SUB_W];
        sel_sub = '0;
        for (int k = NUM_SUB - 1; k >= 0; k--) begin
            if (cand[(int'(start) + k) % NUM_SUB]) begin
                sel_sub = SUB_W'((int'(start) + k) % NUM_SUB);
            end
        end
    end
endmodule

// File: rtl/vl_tx_regulator.sv
// Transmit pacing and multiplexing of virtual links. It holds descriptor
// queues per link and sub-link, one gap timer per link, a round-robin pointer
// and a sequence counter per link. It presents one frame at a time and waits
// for out_done. Assumes ms_tick is a one-cycle pulse and that the
// configuration inputs are quasi-static.
module vl_tx_regulator
    import vlr_pkg::*;
#(
    parameter int  NUM_VL  = 4,
    parameter int  NUM_SUB = 2,
    parameter int  QDEPTH  = 4,
    parameter int  LEN_W   = 11,
    parameter int  DROP_W  = 16,
    localparam int VL_W    = (NUM_VL > 1) ? $clog2(NUM_VL) : 1,
    localparam int SUB_W   = (NUM_SUB > 1) ? $clog2(NUM_SUB) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      ms_tick,
    input  logic                      enq_valid,
    input  logic [VL_W-1:0]           enq_vl,
    input  logic [SUB_W-1:0]          enq_sub,
    input  logic [LEN_W-1:0]          enq_len,
    output logic                      enq_accept,
    input  logic [NUM_VL*BAGX_W-1:0]  cfg_bag_exp,
    input  logic [NUM_VL*LEN_W-1:0]   cfg_lmax,
    input  logic [NUM_VL*NET_W-1:0]   cfg_net_en,
    output logic                      out_valid,
    output logic [VL_W-1:0]           out_vl,
    output logic [SUB_W-1:0]          out_sub,
    output logic [LEN_W-1:0]          out_len,
    output logic [SEQ_W-1:0]          out_seq,
    output logic [NET_W-1:0]          out_net_mask,
    input  logic                      out_done,
    output logic [DROP_W-1:0]         drop_count
);
    localparam int NUM_Q = NUM_VL * NUM_SUB;

    logic [NUM_Q-1:0]        q_push, q_pop, q_empty, q_full;
    logic [LEN_W-1:0]        q_head [NUM_Q];
    logic [NUM_VL-1:0]       vl_ready, vl_load;
    logic [SUB_W-1:0]        rr_q   [NUM_VL];
    logic [NUM_VL*SUB_W-1:0] rr_flat;
    logic [SEQ_W-1:0]        seq_q  [NUM_VL];
    sch_state_e              state_q;

    logic                    pick_found, take, pick_oversize, enq_in_range;
    logic [VL_W-1:0]         pick_vl;
    logic [SUB_W-1:0]        pick_sub, rr_next;
    int                      pick_q, enq_q;
    logic [LEN_W-1:0]        pick_len, pick_lmax;

    // One descriptor FIFO per (link, sub-link).
    for (genvar g = 0; g < NUM_Q; g++) begin : g_queue
        vlr_desc_fifo #(.DEPTH(QDEPTH), .W(LEN_W)) u_fifo (
            .clk   (clk),
            .rst_n (rst_n),
            .push  (q_push[g]),
            .pop   (q_pop[g]),
            .din   (enq_len),
            .dout  (q_head[g]),
            .empty (q_empty[g]),
            .full  (q_full[g])
        );
    end

    // One gap timer per link, plus flattening of the round-robin pointers.
    for (genvar gv = 0; gv < NUM_VL; gv++) begin : g_link
        vlr_bag_timer u_timer (
            .clk     (clk),
            .rst_n   (rst_n),
            .ms_tick (ms_tick),
            .load    (vl_load[gv]),
            .bag_exp (cfg_bag_exp[gv*BAGX_W +: BAGX_W]),
            .ready   (vl_ready[gv])
        );
        assign rr_flat[gv*SUB_W +: SUB_W] = rr_q[gv];
    end

    vlr_pick #(
        .NUM_VL (NUM_VL),
        .NUM_SUB(NUM_SUB),
        .VL_W   (VL_W),
        .SUB_W  (SUB_W)
    ) u_pick (
        .vl_ready   (vl_ready),
        .q_nonempty (~q_empty),
        .rr_flat    (rr_flat),
        .found      (pick_found),
        .sel_vl     (pick_vl),
        .sel_sub    (pick_sub)
    );

    // Enqueue steering: route the write to the addressed FIFO when it has room.
    assign enq_in_range = (int'(enq_vl) < NUM_VL) && (int'(enq_sub) < NUM_SUB);
    assign enq_q        = int'(enq_vl) * NUM_SUB + int'(enq_sub);
    always_comb begin
        q_push     = '0;
        enq_accept = 1'b0;
        if (enq_in_range) begin
            enq_accept    = !q_full[enq_q];
            q_push[enq_q] = enq_valid && !q_full[enq_q];
        end
    end

    // Selection datapath: head length, the link's limit and the next pointer.
    assign take          = (state_q == SCH_IDLE) && pick_found;
    assign pick_q        = int'(pick_vl) * NUM_SUB + int'(pick_sub);
    assign pick_len      = q_head[pick_q];
    assign pick_lmax     = cfg_lmax[int'(pick_vl)*LEN_W +: LEN_W];
    assign pick_oversize = pick_len > pick_lmax;
    assign rr_next       = (int'(pick_sub) == NUM_SUB - 1) ? '0 : pick_sub + SUB_W'(1);

    // Pop the chosen head; reload the link timer only for a frame that is sent.
    always_comb begin
        q_pop = '0;
        if (take) begin
            q_pop[pick_q] = 1'b1;
        end
        for (int v = 0; v < NUM_VL; v++) begin
            vl_load[v] = take && !pick_oversize && (int'(pick_vl) == v);
        end
    end

    // Scheduler: select, stamp and present a frame, then wait for out_done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q      <= SCH_IDLE;
            out_valid    <= 1'b0;
            out_vl       <= '0;
            out_sub      <= '0;
            out_len      <= '0;
            out_seq      <= '0;
            out_net_mask <= '0;
            drop_count   <= '0;
            for (int v = 0; v < NUM_VL; v++) begin
                seq_q[v] <= '0;
                rr_q[v]  <= '0;
            end
        end else begin
            case (state_q)
                SCH_IDLE: begin
                    if (take) begin
                        rr_q[pick_vl] <= rr_next;
                        if (pick_oversize) begin
                            drop_count <= drop_count + DROP_W'(1);
                        end else begin
                            out_valid      <= 1'b1;
                            out_vl         <= pick_vl;
                            out_sub        <= pick_sub;
                            out_len        <= pick_len;
                            out_seq        <= seq_q[pick_vl];
                            out_net_mask   <= cfg_net_en[int'(pick_vl)*NET_W +: NET_W];
                            seq_q[pick_vl] <= seq_advance(seq_q[pick_vl]);
                            state_q        <= SCH_BUSY;
                        end
                    end
                end
                SCH_BUSY: begin
                    if (out_done) begin
                        out_valid <= 1'b0;
                        state_q   <= SCH_IDLE;
                    end
                end
                default: state_q <= SCH_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/vlr_checker.sv
// Protocol and policy checks on the regulator. Attached to every instance
// of the top module by the bind at the end of this file.
module vlr_checker #(
    parameter int NUM_VL = 4,
    parameter int LEN_W  = 11,
    parameter int VL_W   = 2,
    parameter int DROP_W = 16
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    out_valid,
    input logic                    out_done,
    input logic [VL_W-1:0]         out_vl,
    input logic [LEN_W-1:0]        out_len,
    input logic [7:0]              out_seq,
    input logic [NUM_VL*LEN_W-1:0] cfg_lmax,
    input logic [NUM_VL-1:0]       vl_ready,
    input logic [DROP_W-1:0]       drop_count
);
    logic [NUM_VL-1:0]       prev_ready;
    logic [NUM_VL*LEN_W-1:0] prev_lmax;
    logic                    ready_at_pick;
    logic [LEN_W-1:0]        lmax_at_pick;

    // Remember timer state and limits of the cycle in which a frame was chosen.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_ready <= '0;
            prev_lmax  <= '0;
        end else begin
            prev_ready <= vl_ready;
            prev_lmax  <= cfg_lmax;
        end
    end

    assign ready_at_pick = prev_ready[out_vl];
    assign lmax_at_pick  = prev_lmax[int'(out_vl)*LEN_W +: LEN_W];

    // R3: a frame only appears for a link whose gap timer had run out.
    a_r3_gap_elapsed: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> ready_at_pick);

    // R7: a presented frame never exceeds its link's limit.
    a_r7_len_within_limit: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> (out_len <= lmax_at_pick));

    // R7: the discard counter moves by at most one per cycle.
    a_r7_drop_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        (drop_count - $past(drop_count)) <= DROP_W'(1));

    // R9: the presented frame holds until acknowledged.
    a_r9_hold_until_done: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_done) |=> (out_valid && $stable(out_vl)
                                      && $stable(out_len) && $stable(out_seq)));

    // R9: acknowledgement retires the frame in the next cycle.
    a_r9_clear_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_done) |=> !out_valid);
endmodule

bind vl_tx_regulator vlr_checker #(
    .NUM_VL (NUM_VL),
    .LEN_W  (LEN_W),
    .VL_W   (VL_W),
    .DROP_W (DROP_W)
) u_vlr_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .out_valid  (out_valid),
    .out_done   (out_done),
    .out_vl     (out_vl),
    .out_len    (out_len),
    .out_seq    (out_seq),
    .cfg_lmax   (cfg_lmax),
    .vl_ready   (vl_ready),
    .drop_count (drop_count)
);

// File: tb/vl_tx_regulator_bench.sv
// Bench: transaction-level reference model stepped after every stimulus,
// with directed corner cases followed by seeded random traffic.
module vl_tx_regulator_bench;
    localparam int NV = 4, NS = 2, QD = 4, LW = 11, DW = 16;
    localparam int SETTLE = 40;

    logic clk = 1'b0, rst_n = 1'b0, ms_tick = 1'b0;
    logic enq_valid = 1'b0;
    logic [1:0] enq_vl = '0;
    logic [0:0] enq_sub = '0;
    logic [LW-1:0] enq_len = '0;
    logic enq_accept;
    logic [NV*3-1:0] cfg_bag_exp;
    logic [NV*LW-1:0] cfg_lmax;
    logic [NV*2-1:0] cfg_net_en;
    logic out_valid, out_done = 1'b0;
    logic [1:0] out_vl;
    logic [0:0] out_sub;
    logic [LW-1:0] out_len;
    logic [7:0] out_seq;
    logic [1:0] out_net_mask;
    logic [DW-1:0] drop_count;

    int c_exp[NV], c_lmax[NV], c_mask[NV];
    int mq[NV][NS][QD];
    int mcnt[NV][NS];
    int m_tmr[NV], m_rr[NV], m_seq[NV];
    int m_drops;
    bit m_busy;
    int e_vl, e_sub, e_len, e_seq, e_mask;
    int n_chk = 0, n_bad = 0;

    always #10 clk = ~clk;

    always_comb begin
        for (int v = 0; v < NV; v++) begin
            cfg_bag_exp[v*3 +: 3] = 3'(c_exp[v]);
            cfg_lmax[v*LW +: LW]  = LW'(c_lmax[v]);
            cfg_net_en[v*2 +: 2]  = 2'(c_mask[v]);
        end
    end

    vl_tx_regulator #(.NUM_VL(NV), .NUM_SUB(NS), .QDEPTH(QD), .LEN_W(LW), .DROP_W(DW))
    u_vl_tx_regulator (
        .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick),
        .enq_valid(enq_valid), .enq_vl(enq_vl), .enq_sub(enq_sub), .enq_len(enq_len),
        .enq_accept(enq_accept),
        .cfg_bag_exp(cfg_bag_exp), .cfg_lmax(cfg_lmax), .cfg_net_en(cfg_net_en),
        .out_valid(out_valid), .out_vl(out_vl), .out_sub(out_sub), .out_len(out_len),
        .out_seq(out_seq), .out_net_mask(out_net_mask), .out_done(out_done),
        .drop_count(drop_count)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%0d exp=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Reference: the next sequence number after s (R8 wrap rule).
    function automatic int seq_next(input int s);
        return (s == 255) ? 1 : s + 1;
    endfunction

    // Reference selection: discard oversize heads, then present at most one frame.
    task automatic model_resolve();
        int v, s, len;
        if (m_busy) return;
        while (1) begin
            v = -1;
            for (int i = NV - 1; i >= 0; i--)
                if (m_tmr[i] == 0 && (mcnt[i][0] + mcnt[i][1]) > 0) v = i;
            if (v < 0) break;
            s = (mcnt[v][m_rr[v]] > 0) ? m_rr[v] : (m_rr[v] + 1) % NS;
            len = mq[v][s][0];
            for (int k = 0; k < QD - 1; k++) mq[v][s][k] = mq[v][s][k+1];
            mcnt[v][s]--;
            m_rr[v] = (s + 1) % NS;
            if (len > c_lmax[v]) begin
                m_drops++;
                continue;
            end
            e_vl = v; e_sub = s; e_len = len; e_seq = m_seq[v]; e_mask = c_mask[v];
            m_seq[v] = seq_next(m_seq[v]);
            m_tmr[v] = 1 << c_exp[v];
            m_busy = 1'b1;
            break;
        end
    endtask

    // Let the design settle, then compare every output with the reference.
    task automatic settle();
        bit was_busy = m_busy;
        model_resolve();
        repeat (was_busy ? 2 : SETTLE) @(negedge clk);
        check(out_valid == m_busy, "R4 frame presence", int'(out_valid), int'(m_busy));
        if (m_busy && out_valid) begin
            check(int'(out_vl) == e_vl, "R5 link order", int'(out_vl), e_vl);
            check(int'(out_sub) == e_sub, "R6 sub-queue turn", int'(out_sub), e_sub);
            check(int'(out_len) == e_len, "R2 length/order", int'(out_len), e_len);
            check(int'(out_seq) == e_seq, "R8 sequence", int'(out_seq), e_seq);
            check(int'(out_net_mask) == e_mask, "R10 net mask", int'(out_net_mask), e_mask);
        end
        check(int'(drop_count) == m_drops, "R7 drop count", int'(drop_count), m_drops);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        m_busy = 1'b0;
        m_drops = 0;
        for (int v = 0; v < NV; v++) begin
            m_tmr[v] = 0; m_rr[v] = 0; m_seq[v] = 0;
            for (int s = 0; s < NS; s++) mcnt[v][s] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(out_valid == 1'b0, "R1 reset out_valid", int'(out_valid), 0);
        check(drop_count == '0, "R1 reset drop_count", int'(drop_count), 0);
        check(enq_accept == 1'b1, "R1 reset queue empty", int'(enq_accept), 1);
    endtask

    task automatic do_enq(input int v, input int s, input int len);
        bit exp_acc;
        @(negedge clk);
        enq_valid = 1'b1; enq_vl = 2'(v); enq_sub = 1'(s); enq_len = LW'(len);
        #1;
        exp_acc = (mcnt[v][s] < QD);
        check(enq_accept == exp_acc, "R2 accept", int'(enq_accept), int'(exp_acc));
        @(negedge clk);
        enq_valid = 1'b0;
        if (exp_acc) begin
            mq[v][s][mcnt[v][s]] = len;
            mcnt[v][s]++;
        end
        settle();
    endtask

    task automatic do_tick();
        @(negedge clk);
        ms_tick = 1'b1;
        @(negedge clk);
        ms_tick = 1'b0;
        for (int v = 0; v < NV; v++) if (m_tmr[v] > 0) m_tmr[v]--;
        settle();
    endtask

    task automatic do_done();
        @(negedge clk);
        out_done = 1'b1;
        @(negedge clk);
        out_done = 1'b0;
        m_busy = 1'b0;
        settle();
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL R9 watchdog act=%0d exp=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0A11));
        c_exp  = '{0, 1, 2, 3};
        c_lmax = '{1518, 100, 1518, 64};
        c_mask = '{3, 1, 2, 3};
        do_reset();

        // R1 and R3: the first frame carries 0; a gap of 4 ticks (exponent 2) on link 2.
        do_enq(2, 0, 20);
        check(out_seq == 8'd0, "R1 first sequence", int'(out_seq), 0);
        do_done();
        do_enq(2, 0, 21);
        do_tick(); do_tick(); do_tick();
        check(out_valid == 1'b0, "R3 gap not yet elapsed", int'(out_valid), 0);
        do_tick();
        check(out_valid == 1'b1, "R3 gap elapsed", int'(out_valid), 1);
        do_done();
        repeat (8) do_tick();

        // R5: with links 0..2 all waiting, link 0 is served first.
        do_enq(2, 1, 30);
        do_enq(1, 0, 31);
        do_enq(0, 0, 32);
        do_done();
        check(out_vl == 2'd0, "R5 lowest link first", int'(out_vl), 0);
        do_done();
        repeat (8) do_tick();
        do_done();

        // R6: both sub-queues of link 0 are loaded and served alternately.
        do_enq(3, 0, 10);
        do_enq(0, 0, 40); do_enq(0, 0, 41); do_enq(0, 1, 42); do_enq(0, 1, 43);
        for (int i = 0; i < 4; i++) begin
            do_done();
            do_tick();
        end

        // R7: link 3 limit 64; 65 is dropped, 64 passes; R2: the fifth entry is refused.
        repeat (8) do_tick();
        if (m_busy) do_done();
        do_enq(2, 0, 5);
        for (int i = 0; i < 5; i++) do_enq(2, 1, 100 + i);
        do_enq(3, 1, 65);
        do_enq(3, 1, 64);
        repeat (8) do_tick();
        for (int i = 0; i < 6; i++) begin
            if (m_busy) do_done();
            repeat (8) do_tick();
        end
        check(int'(drop_count) == m_drops && m_drops >= 1, "R7 oversize dropped",
              int'(drop_count), m_drops);

        // R8: 256 frames on link 0, then the wrap from 255 to 1.
        do_reset();
        for (int i = 0; i < 256; i++) begin
            do_enq(0, 0, 10);
            do_done();
            do_tick();
        end
        do_enq(0, 0, 11);
        check(out_seq == 8'd1, "R8 wrap to one", int'(out_seq), 1);
        do_done();

        // Random traffic with lengths clustered around the limits.
        for (int i = 0; i < 1500; i++) begin
            int r, v, s, len;
            r = int'($urandom % 10);
            if (r < 4) begin
                v = int'($urandom % NV);
                s = int'($urandom % NS);
                if ($urandom % 2 == 0) len = 1 + int'($urandom % 1518);
                else len = c_lmax[v] - 1 + int'($urandom % 3);
                do_enq(v, s, len);
            end else if (r < 7 || !m_busy) begin
                do_tick();
            end else begin
                do_done();
            end
        end

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule